// File: doc/BRIEF.md
# Scatter-Gather Resume Offset Locator

This block resumes a DMA transfer part-way through a physical-region descriptor table. A command supplies the options word, the command-table base address and the byte offset to resume from. The block takes the entry count from the upper half of the options word and presents the table fetch address. It then accepts descriptor entries one at a time on a valid/ready stream. Each entry holds a 64-bit address and a zero-based byte count.

While it walks the entries, the block keeps a running sum of the real entry lengths. The first entry whose end reaches the offset is the selected one. That entry is emitted trimmed by the offset. Every entry after it is emitted whole, as address/length pairs on an output valid/ready stream. Entries before the selected one are consumed and dropped. A one-cycle done pulse closes each command and carries the total emitted byte count. An error flag is raised with the pulse when the table is empty or the offset lies beyond the table, and no segment is emitted in that case.

Top module: `sgl_offset_locator`

## Requirements
- R1: The entry count is bits 31:16 of the options word, and bits 15:0 are ignored. On command acceptance `tbl_addr` becomes the command-table base plus 0x80 (128).
- R2: An entry count of zero gives `done` and `err` together in the second cycle after the command is accepted. No entry is accepted and no segment is emitted.
- R3: The real length of an entry is its byte-count field plus one.
- R4: Entries are taken in order. The selected entry is the first entry k for which offset <= S + len(k), where S is the sum of the real lengths of the entries before it. Entries before it are accepted but not emitted. Exactly `count` entries are accepted for every nonzero count.
- R5: The first emitted segment has address addr(k) + (offset - S) and length len(k) - (offset - S). This length is zero when the offset equals the end of that entry exactly.
- R6: Each entry after the selected one is emitted with its own address and its full real length, in table order.
- R7: If no entry is selected, `err` is raised with `done`, `total` is zero, and no segment is emitted.
- R8: `done` is a single-cycle pulse. When segments are emitted, it is seen in the cycle after the last segment handshake, and `total` then equals the sum of the emitted lengths.
- R9: A segment held with `seg_ready` low keeps its address and length unchanged. `ent_ready` is high only while the output slot is free or draining.
- R10: `cmd_ready` is high only when no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_opts | input | OPTS_W | Command-header options word (count in upper half) |
| cmd_tbl_base | input | AW | Command-table base address |
| cmd_offset | input | SW | Byte offset to resume from |
| tbl_addr | output | AW | Address of the first descriptor entry |
| ent_valid | input | 1 | Descriptor entry present |
| ent_ready | output | 1 | Descriptor entry taken |
| ent_addr | input | AW | Entry address |
| ent_cnt | input | LW | Entry byte count, zero-based |
| seg_valid | output | 1 | Segment present |
| seg_ready | input | 1 | Segment taken |
| seg_addr | output | AW | Segment start address |
| seg_len | output | LW+1 | Segment length in bytes |
| done | output | 1 | One-cycle end-of-command pulse |
| err | output | 1 | Empty table or unreachable offset, valid with done |
| total | output | SW+1 | Emitted byte count, valid with done |

## Verification
The assertions assume that the sender of entries holds address and count steady while `ent_valid` waits for `ent_ready`. They also assume that it supplies exactly the announced number of entries and that offsets fit the sum width. The bench always presents entries from one fixed six-entry pool, never exceeds that count, and drops `ent_valid` only after the handshake. Output backpressure follows a repeating pattern so that held segments occur under the stream-stability property.

// File: rtl/sgl_pkg.sv
package sgl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WALK  = 2'd1,
      ST_DRAIN = 2'd2
   } sgl_state_e;

endpackage

// File: rtl/sgl_cmd_decode.sv
module sgl_cmd_decode #(
   parameter int AW      = 64,
   parameter int OPTS_W  = 32,
   parameter int CNT_LSB = 16,
   parameter int TBL_OFS = 128,
   localparam int CW     = OPTS_W - CNT_LSB
) (
   input  logic [OPTS_W-1:0] opts,
   input  logic [AW-1:0]     base,
   output logic [CW-1:0]     count,
   output logic [AW-1:0]     tbl
);

   generate
      if (CNT_LSB < 0 || CNT_LSB >= OPTS_W) begin : g_bad_lsb
         $error("sgl_cmd_decode: CNT_LSB out of range");
      end
      if (CNT_LSB == 0) begin : g_whole
         assign count = opts;
      end else begin : g_slice
         logic [CNT_LSB-1:0] unused_low;
         assign unused_low = opts[CNT_LSB-1:0];
         assign count      = opts[OPTS_W-1:CNT_LSB];
      end
   endgenerate

   assign tbl = base + AW'(TBL_OFS);

endmodule

// File: rtl/sgl_seg_walker.sv
module sgl_seg_walker #(
   parameter int AW = 64,
   parameter int LW = 22,
   parameter int SW = 38
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          chk_en,
   input  logic          found,
   input  logic [SW-1:0] offset,
   input  logic [SW-1:0] sum,
   input  logic [AW-1:0] ent_addr,
   input  logic [LW-1:0] ent_cnt,
   output logic          take,
   output logic          emit,
   output logic [AW-1:0] seg_addr,
   output logic [LW:0]   seg_len,
   output logic [SW-1:0] sum_next
);

   logic [LW:0]   len;
   logic [SW:0]   reach;
   logic [SW-1:0] pos;

   generate
      if (SW <= LW) begin : g_bad_sw
         $error("sgl_seg_walker: SW must exceed LW");
      end
      if (AW <= SW) begin : g_bad_aw
         $error("sgl_seg_walker: AW must exceed SW");
      end
   endgenerate

   always_comb begin
      len   = {1'b0, ent_cnt} + (LW+1)'(1);
      reach = {1'b0, sum} + (SW+1)'(len);
      take  = !found && ({1'b0, offset} <= reach);
      emit  = found || take;
      pos   = offset - sum;
      if (take) begin
         seg_addr = ent_addr + {{(AW-SW){1'b0}}, pos};
         seg_len  = len - pos[LW:0];
      end else begin
         seg_addr = ent_addr;
         seg_len  = len;
      end
      sum_next = emit ? sum : reach[SW-1:0];
   end

   AST_POS_IN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && take) |-> (pos[SW-1:LW+1] == '0 && pos[LW:0] <= len)); // R5

   AST_SKIP_GROWS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && !emit) |-> (sum_next > sum)); // R4

endmodule

// File: rtl/sgl_offset_locator.sv
module sgl_offset_locator
   import sgl_pkg::*;
#(
   parameter int AW      = 64,
   parameter int LW      = 22,
   parameter int OPTS_W  = 32,
   parameter int CNT_LSB = 16,
   parameter int TBL_OFS = 128,
   parameter int SW      = LW + OPTS_W - CNT_LSB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [OPTS_W-1:0] cmd_opts,
   input  logic [AW-1:0]     cmd_tbl_base,
   input  logic [SW-1:0]     cmd_offset,
   output logic [AW-1:0]     tbl_addr,
   input  logic              ent_valid,
   output logic              ent_ready,
   input  logic [AW-1:0]     ent_addr,
   input  logic [LW-1:0]     ent_cnt,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [AW-1:0]     seg_addr,
   output logic [LW:0]       seg_len,
   output logic              done,
   output logic              err,
   output logic [SW:0]       total
);

   localparam int CW = OPTS_W - CNT_LSB;

   generate
      if (SW < LW + CW) begin : g_bad_sum
         $error("sgl_offset_locator: SW too narrow for count times length");
      end
   endgenerate

   sgl_state_e    state_q;
   logic [CW-1:0] remain_q;
   logic [SW-1:0] offset_q;
   logic [SW-1:0] sum_q;
   logic          found_q;
   logic [SW:0]   total_q;
   logic          segv_q;
   logic [AW-1:0] sega_q;
   logic [LW:0]   segl_q;
   logic          done_q;
   logic          err_q;
   logic [AW-1:0] tbl_q;

   logic [CW-1:0] dec_count;
   logic [AW-1:0] dec_tbl;
   logic          w_take;
   logic          w_emit;
   logic [AW-1:0] w_addr;
   logic [LW:0]   w_len;
   logic [SW-1:0] w_sum;
   logic          ent_fire;
   logic          slot_free;

   sgl_cmd_decode #(
      .AW(AW), .OPTS_W(OPTS_W), .CNT_LSB(CNT_LSB), .TBL_OFS(TBL_OFS)
   ) u_dec (
      .opts  (cmd_opts),
      .base  (cmd_tbl_base),
      .count (dec_count),
      .tbl   (dec_tbl)
   );

   sgl_seg_walker #(.AW(AW), .LW(LW), .SW(SW)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .chk_en   (ent_fire),
      .found    (found_q),
      .offset   (offset_q),
      .sum      (sum_q),
      .ent_addr (ent_addr),
      .ent_cnt  (ent_cnt),
      .take     (w_take),
      .emit     (w_emit),
      .seg_addr (w_addr),
      .seg_len  (w_len),
      .sum_next (w_sum)
   );

   assign slot_free = !segv_q || seg_ready;
   assign ent_ready = (state_q == ST_WALK) && slot_free;
   assign ent_fire  = ent_valid && ent_ready;
   assign cmd_ready = (state_q == ST_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         remain_q <= '0;
         offset_q <= '0;
         sum_q    <= '0;
         found_q  <= 1'b0;
         total_q  <= '0;
         segv_q   <= 1'b0;
         sega_q   <= '0;
         segl_q   <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         tbl_q    <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (segv_q && seg_ready) begin
            segv_q <= 1'b0;
         end
         case (state_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  offset_q <= cmd_offset;
                  remain_q <= dec_count;
                  sum_q    <= '0;
                  found_q  <= 1'b0;
                  total_q  <= '0;
                  tbl_q    <= dec_tbl;
                  state_q  <= (dec_count == '0) ? ST_DRAIN : ST_WALK;
               end
            end
            ST_WALK: begin
               if (ent_fire) begin
                  remain_q <= remain_q - CW'(1);
                  sum_q    <= w_sum;
                  if (w_take) begin
                     found_q <= 1'b1;
                  end
                  if (w_emit) begin
                     segv_q  <= 1'b1;
                     sega_q  <= w_addr;
                     segl_q  <= w_len;
                     total_q <= total_q + (SW+1)'(w_len);
                  end
                  if (remain_q == CW'(1)) begin
                     state_q <= ST_DRAIN;
                  end
               end
            end
            ST_DRAIN: begin
               if (slot_free) begin
                  done_q  <= 1'b1;
                  err_q   <= !found_q;
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign tbl_addr  = tbl_q;
   assign seg_valid = segv_q;
   assign seg_addr  = sega_q;
   assign seg_len   = segl_q;
   assign done      = done_q;
   assign err       = err_q;
   assign total     = total_q;

   AST_SEG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len))); // R9

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R8

   AST_DONE_AFTER_SEGS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !seg_valid); // R8

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (done && total == '0)); // R7

   AST_CMD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      ent_ready |-> !cmd_ready); // R10

endmodule

// File: tb/sgl_offset_locator_tb_top.sv
`timescale 1ns/1ps
module sgl_offset_locator_tb_top;

   localparam int AW = 64;
   localparam int LW = 22;
   localparam int OPTS_W = 32;
   localparam int SW = 38;
   localparam logic [AW-1:0] BASE = 64'h0000_0040_0000_1000;

   typedef struct packed {
      logic [15:0] cnt;
      logic [37:0] off;
      logic        bp;
      logic        err;
      logic [38:0] tot;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{16'd3, 38'd0,   1'b0, 1'b0, 39'd160},
      '{16'd3, 38'd120, 1'b1, 1'b0, 39'd40},
      '{16'd6, 38'd100, 1'b1, 1'b0, 39'd291},
      '{16'd4, 38'd161, 1'b0, 1'b0, 39'd0},
      '{16'd2, 38'd151, 1'b1, 1'b1, 39'd0},
      '{16'd6, 38'd300, 1'b1, 1'b0, 39'd91},
      '{16'd1, 38'd5,   1'b0, 1'b0, 39'd95}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_ready;
   logic [OPTS_W-1:0] cmd_opts = '0;
   logic [AW-1:0] cmd_tbl_base = '0;
   logic [SW-1:0] cmd_offset = '0;
   logic [AW-1:0] tbl_addr;
   logic ent_valid = 1'b0;
   logic ent_ready;
   logic [AW-1:0] ent_addr = '0;
   logic [LW-1:0] ent_cnt = '0;
   logic seg_valid;
   logic seg_ready = 1'b0;
   logic [AW-1:0] seg_addr;
   logic [LW:0] seg_len;
   logic done;
   logic err;
   logic [SW:0] total;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   sgl_offset_locator dut_i (
      .clk(clk), .rst_n(rst_n),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_opts(cmd_opts),
      .cmd_tbl_base(cmd_tbl_base), .cmd_offset(cmd_offset), .tbl_addr(tbl_addr),
      .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_addr(ent_addr), .ent_cnt(ent_cnt),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
      .done(done), .err(err), .total(total)
   );

   function automatic logic [LW-1:0] pool_cnt(int k);
      case (k)
         0: return 22'd99;
         1: return 22'd49;
         2: return 22'd9;
         3: return 22'd0;
         4: return 22'd199;
         default: return 22'd29;
      endcase
   endfunction

   function automatic logic [AW-1:0] pool_addr(int k);
      return 64'h0000_A000_0000_0000 + 64'(k) * 64'h1_0000;
   endfunction

   task automatic chk(bit ok, string req, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic [AW-1:0] got_a [8];
   logic [LW:0]   got_l [8];
   int            n_got;
   int            n_ent;

   task automatic drive_entries(int cnt);
      n_ent = 0;
      for (int k = 0; k < cnt; k++) begin
         @(negedge clk);
         ent_valid = 1'b1;
         ent_addr  = pool_addr(k);
         ent_cnt   = pool_cnt(k);
         #2;
         while (!ent_ready) begin
            @(negedge clk);
            #2;
         end
         @(posedge clk);
         n_ent++;
      end
      @(negedge clk);
      ent_valid = 1'b0;
   endtask

   task automatic sink(bit bp, output bit d_err, output logic [SW:0] d_tot, output int gap);
      bit seen = 1'b0;
      bit held = 1'b0;
      logic [AW-1:0] ha;
      logic [LW:0] hl;
      int last_hs = -1;
      n_got = 0;
      gap = 1;
      while (!seen) begin
         @(negedge clk);
         seg_ready = bp ? ((cyc % 3) != 1) : 1'b1;
         #1;
         if (held) begin
            chk(seg_valid && seg_addr == ha && seg_len == hl, "R9", "held segment changed",
                seg_addr, ha);
         end
         held = seg_valid && !seg_ready;
         ha = seg_addr;
         hl = seg_len;
         if (seg_valid && seg_ready && n_got < 8) begin
            got_a[n_got] = seg_addr;
            got_l[n_got] = seg_len;
            n_got++;
            last_hs = cyc;
         end
         if (done) begin
            seen  = 1'b1;
            d_err = err;
            d_tot = total;
            if (last_hs >= 0) gap = cyc - last_hs;
         end
      end
      seg_ready = 1'b0;
   endtask

   task automatic run_vec(vec_t v, logic [15:0] low);
      bit d_err;
      logic [SW:0] d_tot;
      int gap;
      logic [SW-1:0] s;
      int f;
      logic [SW-1:0] pos;
      logic [AW-1:0] ea;
      logic [LW:0] el;
      int ne;
      @(negedge clk);
      cmd_valid    = 1'b1;
      cmd_opts     = {v.cnt, low};
      cmd_tbl_base = BASE;
      cmd_offset   = v.off;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(tbl_addr == BASE + 64'd128, "R1", "table address", tbl_addr, BASE + 64'd128);
      chk(!cmd_ready, "R10", "cmd_ready while busy", 64'(cmd_ready), 64'd0);
      fork
         drive_entries(int'(v.cnt));
         sink(v.bp, d_err, d_tot, gap);
      join
      chk(n_ent == int'(v.cnt), "R4", "entries consumed", 64'(n_ent), 64'(v.cnt));
      chk(d_err == v.err, "R7", "error flag", 64'(d_err), 64'(v.err));
      chk(d_tot == v.tot, "R8", "total bytes", 64'(d_tot), 64'(v.tot));
      chk(gap == 1, "R8", "done gap after last segment", 64'(gap), 64'd1);
      s = '0;
      f = -1;
      pos = '0;
      for (int k = 0; k < int'(v.cnt); k++) begin
         el = (LW+1)'(pool_cnt(k)) + 1;
         if (f < 0) begin
            if (v.off <= s + SW'(el)) begin
               f = k;
               pos = v.off - s;
            end else begin
               s = s + SW'(el);
            end
         end
      end
      ne = (f < 0) ? 0 : int'(v.cnt) - f;
      chk(n_got == ne, "R4", "segment count", 64'(n_got), 64'(ne));
      for (int j = 0; j < ne && j < n_got; j++) begin
         el = (LW+1)'(pool_cnt(f + j)) + 1;
         ea = pool_addr(f + j);
         if (j == 0) begin
            ea = ea + 64'(pos);
            el = el - (LW+1)'(pos);
            chk(got_a[j] == ea, "R5", "first segment address", got_a[j], ea);
            chk(got_l[j] == el, "R5", "first segment length", 64'(got_l[j]), 64'(el));
         end else begin
            chk(got_a[j] == ea, "R6", "later segment address", got_a[j], ea);
            chk(got_l[j] == el, "R3", "later segment full length", 64'(got_l[j]), 64'(el));
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(cmd_ready && !ent_ready && !seg_valid && !done && !err, "R10", "reset state",
          {59'd0, cmd_ready, ent_ready, seg_valid, done, err}, 64'h10);

      for (int i = 0; i < NV; i++) begin
         run_vec(VECS[i], 16'(i * 16'h1111));
      end

      // R2: zero count with low option bits set (ignored, R1)
      @(negedge clk);
      cmd_valid    = 1'b1;
      cmd_opts     = 32'h0000_FFFF;
      cmd_tbl_base = BASE + 64'h100;
      cmd_offset   = 38'd7;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      ent_valid = 1'b1;
      ent_addr  = pool_addr(0);
      ent_cnt   = pool_cnt(0);
      #1;
      chk(!done && !ent_ready, "R2", "first cycle after empty command", 64'({done, ent_ready}), 64'd0);
      chk(tbl_addr == BASE + 64'h180, "R1", "table address empty command", tbl_addr, BASE + 64'h180);
      @(negedge clk);
      #1;
      chk(done && err && !ent_ready, "R2", "empty table error", 64'({done, err, ent_ready}), 64'b110);
      chk(total == '0 && !seg_valid, "R2", "no output for empty table", 64'(total), 64'd0);
      ent_valid = 1'b0;

      repeat (3) @(posedge clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule